// File: doc/BRIEF.md
# Attachment Status Word and Host Interrupt Gating

This block keeps the 16-bit status word of a processor-to-processor attachment and decides when the host side sees an interrupt. Single-cycle event strobes from the transfer logic and from the remote processor set sticky status bits. The remote processor's ready and busy levels appear live in the word. Decoded host commands act on the block: control, initiate read, initiate write and sense. The control command sets up a two-tier gate. A basic permit or prevent state is combined with a temporary prevent that lasts only until the next accepted control or transfer command. This gate decides whether attention and power/thermal events may interrupt the host.

A sense command copies the whole word to `sense_word` and can also clear the resettable bits. A set-interrupt request from the remote processor is answered with a condition code: 0 when it is newly recorded, and 2 when an attention is already pending. Both results are single-cycle pulses with no back-pressure. `sense_word` and `rmt_cc` hold their values until the next sense or set-interrupt. The interrupt appears as a level on `host_irq` and as bit 4 of the level-3 interrupt status word `ilsw`.

Top module: `dsw_attach_status`

## Requirements
- R1: After `rst_n` low or a `por_pulse`, status bits 0 to 6 are zero, the gate is in prevent and `host_irq` is low. Bits 14 and 15 still follow `ready_in` and `busy_in`.
- R2: A strobe sets its status bit one clock later. The bits are: 0 attention, 1 op end, 2 bad address, 3 data check, 4 count zero, 5 power/thermal, 6 storage check. Bit 14 equals `ready_in` and bit 15 equals `busy_in`. Bits 7 to 13 read zero.
- R3: A sense command pulses `sense_vld` one clock later, with `sense_word` holding the word as it stood before that edge. When `cmd_mod_hi[3]` (modifier bit 15) is set, bits 0 to 4 and bit 6 are cleared. Otherwise they are unchanged.
- R4: Bit 5 is never cleared by a sense command.
- R5: A `rmt_set_irq` pulses `rmt_cc_vld` one clock later. `rmt_cc` is 0 and bit 0 is set when bit 0 was clear. `rmt_cc` is 2 and the word is unchanged when bit 0 was already set.
- R6: A pending attention raises `host_irq` only when the gate is open and `busy_in` is low. While busy, the host learns of it only through the op-end interrupt.
- R7: A control command with modifier bit 12 set and bit 13 clear (`cmd_mod_hi[1:0]`=01) sets the basic state to permit. Bit 13 set with bit 12 clear (10) sets prevent. The values 00 and 11 leave the basic state unchanged.
- R8: Modifier bit 14 (`cmd_mod_hi[2]`) in a control command sets a temporary prevent. The next accepted control, initiate read or initiate write command clears it.
- R9: A power/thermal strobe leaves an interrupt cause pending until a clearing sense. That cause raises `host_irq` only while the gate is open.
- R10: `host_irq` stays high while op end is set, and is dropped by the clearing sense. `ilsw` bit 4 equals `host_irq`, and its other bits are zero.
- R11: While `busy_in` is high, control, initiate read and initiate write commands have no effect. Sense is still served.
- R12: An event strobe in the same cycle as a clearing sense wins, and its bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Host channel reset, active low, asynchronous |
| por_pulse | input | 1 | Remote power-on reset, synchronous one-cycle pulse |
| rmt_set_irq | input | 1 | Remote set-interrupt (attention) request strobe |
| op_end | input | 1 | Operation end strobe |
| bad_addr | input | 1 | Invalid remote storage address strobe |
| data_chk | input | 1 | Remote storage parity error strobe |
| cnt_zero | input | 1 | Word count reached zero strobe |
| pwr_warn | input | 1 | Power or thermal warning strobe |
| stor_chk | input | 1 | Remote storage did not respond strobe |
| ready_in | input | 1 | Remote on line with good power (level) |
| busy_in | input | 1 | Transfer in progress (level) |
| cmd_ctrl | input | 1 | Decoded control command strobe |
| cmd_read | input | 1 | Decoded initiate read strobe |
| cmd_write | input | 1 | Decoded initiate write strobe |
| cmd_sense | input | 1 | Decoded sense command strobe |
| cmd_mod_hi | input | 4 | Modifier bits 12 to 15 of the command, index 0 = bit 12 |
| status_word | output | 16 | Current status word |
| sense_vld | output | 1 | Sense result pulse |
| sense_word | output | 16 | Status word captured by the last sense |
| rmt_cc_vld | output | 1 | Condition code pulse to the remote |
| rmt_cc | output | 2 | Condition code to the remote: 0 accepted, 2 already pending |
| host_irq | output | 1 | Level-3 interrupt request to the host |
| ilsw | output | 16 | Level-3 interrupt status word, bit 4 = this attachment |

## Verification
Every registered result lands one clock after its strobe: the status bits, `sense_vld`/`sense_word`, `rmt_cc_vld`/`rmt_cc` and the gate state. `host_irq` and bits 14 and 15 then follow at once from those registers and from the live `busy_in`/`ready_in` levels. The bench drives each strobe on a falling edge and removes it on the next falling edge. It samples the outputs at that second falling edge, which is exactly one rising edge after the stimulus. The one-cycle pulses are therefore seen in their only valid cycle. Level changes of `busy_in` are checked at the falling edge right after they are applied.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int DSW_W   = 16;
  localparam int STK_W   = 7;
  localparam int MODH_W  = 4;
  localparam int ILSW_W  = 16;
  localparam int ILSW_BIT = 4;

  localparam int B_ATTN   = 0;
  localparam int B_OPEND  = 1;
  localparam int B_PWR    = 5;
  localparam int B_READY  = 14;
  localparam int B_BUSY   = 15;

  // modifier bits 12..15 arrive as cmd_mod_hi[0..3]
  localparam int MB_PERMIT  = 0;
  localparam int MB_PREVENT = 1;
  localparam int MB_TEMP    = 2;
  localparam int MB_CLR     = 3;

  localparam logic [STK_W-1:0] CLR_MASK = 7'b101_1111;
  localparam logic [1:0] CC_OK   = 2'd0;
  localparam logic [1:0] CC_PEND = 2'd2;
endpackage

// File: rtl/dsw_status_reg.sv
module dsw_status_reg
  import dsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por,
  input  logic [STK_W-1:0] set_v,
  input  logic             sense_clr,
  output logic [STK_W-1:0] st_q,
  output logic             pwr_pend
);
  logic [STK_W-1:0] keep_mask;

  always_comb keep_mask = sense_clr ? ~CLR_MASK : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= '0;
      pwr_pend <= 1'b0;
    end else if (por) begin
      st_q     <= '0;
      pwr_pend <= 1'b0;
    end else begin
      st_q     <= (st_q & keep_mask) | set_v;
      pwr_pend <= set_v[B_PWR] | (pwr_pend & ~sense_clr);
    end
  end

  // R4: power/thermal bit only leaves through reset
  p_sticky_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n || por)
    st_q[B_PWR] |=> st_q[B_PWR]);

  // R3: clearing sense with no coinciding event empties the resettable bits
  p_sense_clear_r3: assert property (@(posedge clk) disable iff (!rst_n || por)
    (sense_clr && set_v == '0) |=> ((st_q & CLR_MASK) == '0));
endmodule

// File: rtl/dsw_irq_gate.sv
module dsw_irq_gate
  import dsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por,
  input  logic       ctl_go,
  input  logic       xfer_go,
  input  logic [2:0] ctl_bits,
  output logic       gate_open
);
  logic basic_q;
  logic temp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      basic_q <= 1'b0;
      temp_q  <= 1'b0;
    end else if (por) begin
      basic_q <= 1'b0;
      temp_q  <= 1'b0;
    end else if (ctl_go) begin
      if (ctl_bits[MB_PERMIT] && !ctl_bits[MB_PREVENT])
        basic_q <= 1'b1;
      else if (!ctl_bits[MB_PERMIT] && ctl_bits[MB_PREVENT])
        basic_q <= 1'b0;
      temp_q <= ctl_bits[MB_TEMP];
    end else if (xfer_go) begin
      temp_q <= 1'b0;
    end
  end

  always_comb gate_open = basic_q & ~temp_q;

  p_temp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_go && ctl_bits[MB_TEMP]) |=> !gate_open);

  p_por_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> !gate_open);
endmodule

// File: rtl/dsw_attach_status.sv
module dsw_attach_status
  import dsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_pulse,
  input  logic              rmt_set_irq,
  input  logic              op_end,
  input  logic              bad_addr,
  input  logic              data_chk,
  input  logic              cnt_zero,
  input  logic              pwr_warn,
  input  logic              stor_chk,
  input  logic              ready_in,
  input  logic              busy_in,
  input  logic              cmd_ctrl,
  input  logic              cmd_read,
  input  logic              cmd_write,
  input  logic              cmd_sense,
  input  logic [MODH_W-1:0] cmd_mod_hi,
  output logic [DSW_W-1:0]  status_word,
  output logic              sense_vld,
  output logic [DSW_W-1:0]  sense_word,
  output logic              rmt_cc_vld,
  output logic [1:0]        rmt_cc,
  output logic              host_irq,
  output logic [ILSW_W-1:0] ilsw
);
  localparam int GAP_W = DSW_W - STK_W - 2;

  logic [STK_W-1:0] st_q;
  logic [STK_W-1:0] set_v;
  logic             pwr_pend;
  logic             gate_open;
  logic             ctl_go, xfer_go, sense_clr, attn_new;

  always_comb begin
    ctl_go    = cmd_ctrl & ~busy_in;
    xfer_go   = (cmd_read | cmd_write) & ~busy_in;
    sense_clr = cmd_sense & cmd_mod_hi[MB_CLR];
    attn_new  = rmt_set_irq & ~st_q[B_ATTN];
    set_v     = {stor_chk, pwr_warn, cnt_zero, data_chk, bad_addr, op_end, attn_new};
  end

  dsw_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .por(por_pulse),
    .set_v(set_v), .sense_clr(sense_clr),
    .st_q(st_q), .pwr_pend(pwr_pend)
  );

  dsw_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .por(por_pulse),
    .ctl_go(ctl_go), .xfer_go(xfer_go),
    .ctl_bits(cmd_mod_hi[2:0]), .gate_open(gate_open)
  );

  always_comb begin
    status_word = {busy_in, ready_in, {GAP_W{1'b0}}, st_q};
    host_irq    = st_q[B_OPEND]
                | (st_q[B_ATTN] & gate_open & ~busy_in)
                | (pwr_pend & gate_open);
    ilsw           = '0;
    ilsw[ILSW_BIT] = host_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_vld  <= 1'b0;
      sense_word <= '0;
      rmt_cc_vld <= 1'b0;
      rmt_cc     <= CC_OK;
    end else begin
      sense_vld  <= cmd_sense;
      rmt_cc_vld <= rmt_set_irq;
      if (cmd_sense)   sense_word <= status_word;
      if (rmt_set_irq) rmt_cc <= st_q[B_ATTN] ? CC_PEND : CC_OK;
    end
  end

  p_opend_irq_r10: assert property (@(posedge clk) disable iff (!rst_n || por_pulse)
    op_end |=> host_irq);

  p_cc_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rmt_set_irq && status_word[B_ATTN]) |=> (rmt_cc_vld && rmt_cc == CC_PEND));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_in && !por_pulse) |=> $stable(gate_open));
endmodule

// File: tb/dsw_attach_status_bench.sv
module dsw_attach_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_pulse = 0, rmt_set_irq = 0, op_end = 0, bad_addr = 0, data_chk = 0;
  logic cnt_zero = 0, pwr_warn = 0, stor_chk = 0, ready_in = 0, busy_in = 0;
  logic cmd_ctrl = 0, cmd_read = 0, cmd_write = 0, cmd_sense = 0;
  logic [3:0] cmd_mod_hi = '0;
  logic [15:0] status_word, sense_word, ilsw;
  logic sense_vld, rmt_cc_vld, host_irq;
  logic [1:0] rmt_cc;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dsw_attach_status u_dsw_attach_status (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .rmt_set_irq(rmt_set_irq),
    .op_end(op_end), .bad_addr(bad_addr), .data_chk(data_chk), .cnt_zero(cnt_zero),
    .pwr_warn(pwr_warn), .stor_chk(stor_chk), .ready_in(ready_in), .busy_in(busy_in),
    .cmd_ctrl(cmd_ctrl), .cmd_read(cmd_read), .cmd_write(cmd_write), .cmd_sense(cmd_sense),
    .cmd_mod_hi(cmd_mod_hi), .status_word(status_word), .sense_vld(sense_vld),
    .sense_word(sense_word), .rmt_cc_vld(rmt_cc_vld), .rmt_cc(rmt_cc),
    .host_irq(host_irq), .ilsw(ilsw)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // release all strobes one rising edge after they were applied
  task automatic tick();
    @(negedge clk);
    por_pulse = 0; rmt_set_irq = 0; op_end = 0; bad_addr = 0; data_chk = 0;
    cnt_zero = 0; pwr_warn = 0; stor_chk = 0;
    cmd_ctrl = 0; cmd_read = 0; cmd_write = 0; cmd_sense = 0; cmd_mod_hi = '0;
  endtask

  task automatic ctrl(input logic [3:0] m);
    cmd_ctrl = 1; cmd_mod_hi = m; tick();
  endtask

  task automatic sense_clear();
    cmd_sense = 1; cmd_mod_hi = 4'b1000; tick();
  endtask

  task automatic t_reset();
    chk("R1 word after reset", status_word, 16'h0000);
    chk("R1 irq after reset", host_irq, 0);
    chk("R10 ilsw after reset", ilsw, 16'h0000);
  endtask

  task automatic t_events_sense();
    ready_in = 1;
    bad_addr = 1; data_chk = 1; cnt_zero = 1; stor_chk = 1; tick();
    chk("R2 error bits and ready", status_word, 16'h405C);
    chk("R2 no irq without op end", host_irq, 0);
    cmd_sense = 1; tick();
    chk("R3 sense pulse", sense_vld, 1);
    chk("R3 sense word", sense_word, 16'h405C);
    chk("R3 read-only sense keeps bits", status_word, 16'h405C);
    sense_clear();
    chk("R3 clearing sense", status_word, 16'h4000);
    chk("R3 word before clear", sense_word, 16'h405C);
  endtask

  task automatic t_power();
    pwr_warn = 1; tick();
    chk("R2 power bit", status_word, 16'h4020);
    chk("R9 power gated at prevent", host_irq, 0);
    sense_clear();
    chk("R4 power bit survives clear", status_word, 16'h4020);
    ctrl(4'b0001);
    chk("R9 cleared cause not raised", host_irq, 0);
    pwr_warn = 1; tick();
    chk("R9 power irq when permitted", host_irq, 1);
    sense_clear();
    chk("R10 irq dropped by clear", host_irq, 0);
  endtask

  task automatic t_attention();
    rmt_set_irq = 1; tick();
    chk("R5 cc valid", rmt_cc_vld, 1);
    chk("R5 cc accepted", rmt_cc, 0);
    chk("R6 attention irq", host_irq, 1);
    chk("R10 ilsw bit4", ilsw, 16'h0010);
    rmt_set_irq = 1; tick();
    chk("R5 cc pending", rmt_cc, 2);
    chk("R5 word unchanged", status_word, 16'h4021);
    sense_clear();
    chk("R6 attention cleared", host_irq, 0);
  endtask

  task automatic t_temp();
    ctrl(4'b0101);
    rmt_set_irq = 1; tick();
    chk("R8 temp prevent holds irq", host_irq, 0);
    cmd_read = 1; tick();
    chk("R8 read lifts temp", host_irq, 1);
    sense_clear();
    ctrl(4'b0100);
    cmd_write = 1; tick();
    rmt_set_irq = 1; tick();
    chk("R8 write lifts temp", host_irq, 1);
    sense_clear();
  endtask

  task automatic t_basic_codes();
    ctrl(4'b0000);
    rmt_set_irq = 1; tick();
    chk("R7 code 00 keeps permit", host_irq, 1);
    sense_clear();
    ctrl(4'b0010);
    rmt_set_irq = 1; tick();
    chk("R7 code 10 prevents", host_irq, 0);
    ctrl(4'b0011);
    chk("R7 code 11 keeps prevent", host_irq, 0);
    ctrl(4'b0001);
    chk("R7 code 01 permits", host_irq, 1);
    sense_clear();
  endtask

  task automatic t_busy();
    @(negedge clk); busy_in = 1; #1;
    chk("R2 busy bit", status_word, 16'hC020);
    rmt_set_irq = 1; tick();
    chk("R6 attention deferred while busy", host_irq, 0);
    ctrl(4'b0010);
    cmd_write = 1; tick();
    op_end = 1; tick();
    chk("R6 op end reports", host_irq, 1);
    chk("R6 op end word", status_word, 16'hC023);
    busy_in = 0;
    sense_clear();
    chk("R10 clear drops op end irq", host_irq, 0);
    rmt_set_irq = 1; tick();
    chk("R11 prevent while busy ignored", host_irq, 1);
    sense_clear();
  endtask

  task automatic t_collide();
    cmd_sense = 1; cmd_mod_hi = 4'b1000; cnt_zero = 1; tick();
    chk("R12 event beats clear", status_word, 16'h4030);
    sense_clear();
  endtask

  task automatic t_por();
    por_pulse = 1; tick();
    chk("R1 por clears bits", status_word, 16'h4000);
    rmt_set_irq = 1; tick();
    chk("R1 por closes gate", host_irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_events_sense();
    t_power();
    t_attention();
    t_temp();
    t_basic_codes();
    t_busy();
    t_collide();
    t_por();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule